// File: doc/BRIEF.md
# Thermal Zone Alert Controller

This block turns a stream of digitized temperature codes (a larger code is hotter) into an eight-level thermometer-coded zone register. Each zone bit compares the latest sampled code against its own threshold, which is set by a parameter. Two behaviours with hysteresis are built on the zone register.

The first is a thermal-warning flag, which appears in the status register. The second is an active-low hot line that tells the rest of the system to throttle. Each of the two is set when a higher zone bit rises. It is cleared only when a lower zone bit falls, one code step below the set point.

An active-low alert line tells the host that the warning flag has changed, in either direction. The host reads its two registers through a strobe, a one-bit register select and a registered data bus. Reading the status register releases the alert. A new warning change in the same cycle as the read keeps the alert asserted.

Top module: `thermal_zone_alert`

## Requirements
- R1: Zone bit i is 1 exactly when the last sampled code is at least threshold i. The default thresholds for bits 0 to 7 are 40, 60, 80, 100, 120, 148, 149 and 150. As a result, the zone register is always thermometer coded from bit 0 upward.
- R2: The code is sampled only in a cycle where `temp_vld` is high. Codes presented while `temp_vld` is low leave the zone register, the warning flag, `hot_n` and `alert_n` unchanged.
- R3: The warning flag is set when zone bit 6 goes from 0 to 1 (code rises to 149 or more). The flag is read as bit 1 of the status register (select 0), and all other status bits read 0.
- R4: The warning flag is cleared only when zone bit 5 goes from 1 to 0 (code falls below 148). A code of 148 leaves it set.
- R5: `hot_n` goes low in the cycle after a sample that takes zone bit 7 from 0 to 1 (code 150 or more).
- R6: Once low, `hot_n` returns high only after a sample that takes zone bit 6 from 1 to 0 (code below 149). A code of 149 keeps it low.
- R7: Every change of the warning flag, set or clear, drives `alert_n` low in the cycle after the sample.
- R8: A status read (`rd_stb` high, `rd_sel` 0) drives `alert_n` high on the next cycle. A zone read (`rd_sel` 1) leaves `alert_n` unchanged.
- R9: When a status read and a warning change happen in the same cycle, `alert_n` stays low, and the read returns the status value from before the change.
- R10: After reset, `alert_n` and `hot_n` are high, and the zone register, the warning flag and `rd_data` are zero.
- R11: `rd_data` shows the selected register, with the zone register in bits 7:0, one cycle after `rd_stb`. It holds that value while `rd_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_vld | input | 1 | Sample strobe for `temp_code` |
| temp_code | input | CODE_W | Temperature code, larger is hotter |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 1 | Register select: 0 status, 1 zone |
| rd_data | output | DATA_W | Registered read data |
| alert_n | output | 1 | Active-low alert to the host |
| hot_n | output | 1 | Active-low throttle request |

## Verification
The hardest case to reach is a status read that falls in the same cycle as a sample that changes the warning flag. In that cycle the read returns the old flag, and the alert must stay asserted. The stimulus first makes the code jump from below the release point to well above the hot threshold, so that the flag and the hot line are set by one sample. It then presents a very cold code and a status read on the same strobe edge. The other boundary codes are visited in order so that the hysteresis of each level can be seen at the ports: 148 and 149 for the warning flag, 149 and 150 for the hot line.

// File: rtl/tza_pkg.sv
package tza_pkg;
   localparam int ZONE_N = 8;

   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_ZONE   = 1'b1
   } tza_sel_e;
endpackage

// File: rtl/tza_zone_enc.sv
// Thermometer zone encoder: one comparator per zone bit, registered on the sample strobe.
module tza_zone_enc #(
   parameter int CODE_W = 8,
   parameter int ZONE_N = 8,
   parameter logic [ZONE_N*CODE_W-1:0] THR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] code,
   output logic [ZONE_N-1:0] zone_nxt,
   output logic [ZONE_N-1:0] zone_q
);
   genvar g;
   for (g = 0; g < ZONE_N; g++) begin : g_cmp
      assign zone_nxt[g] = (code >= THR[g*CODE_W +: CODE_W]);
      if (g > 0) begin : g_ord
         if (THR[g*CODE_W +: CODE_W] <= THR[(g-1)*CODE_W +: CODE_W]) begin : g_bad
            $error("zone thresholds must strictly increase with bit index");
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zone_q <= '0;
      end else if (upd) begin
         zone_q <= zone_nxt;
      end
   end
endmodule

// File: rtl/tza_hyst_flag.sv
// Next-state logic for a flag that sets on the rise of one zone bit and clears on the fall of a lower one.
module tza_hyst_flag #(
   parameter int ZONE_N  = 8,
   parameter int SET_BIT = 6,
   parameter int CLR_BIT = 5
) (
   input  logic              upd,
   input  logic              flag_q,
   input  logic [ZONE_N-1:0] zone_old,
   input  logic [ZONE_N-1:0] zone_new,
   output logic              flag_nxt
);
   if (SET_BIT <= CLR_BIT || SET_BIT >= ZONE_N) begin : g_chk
      $error("set bit must sit above clear bit inside the zone register");
   end

   logic set_evt;
   logic clr_evt;

   always_comb begin
      set_evt  = upd & ~zone_old[SET_BIT] & zone_new[SET_BIT];
      clr_evt  = upd &  zone_old[CLR_BIT] & ~zone_new[CLR_BIT];
      flag_nxt = flag_q;
      if (clr_evt) begin
         flag_nxt = 1'b0;
      end else if (set_evt) begin
         flag_nxt = 1'b1;
      end
   end
endmodule

// File: rtl/tza_alert_ctl.sv
// Active-low alert: asserted on any flag change, released by a status read; the change wins.
module tza_alert_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic chg,
   input  logic rd_clr,
   output logic alert_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_n <= 1'b1;
      end else if (chg) begin
         alert_n <= 1'b0;
      end else if (rd_clr) begin
         alert_n <= 1'b1;
      end
   end
endmodule

// File: rtl/thermal_zone_alert.sv
module thermal_zone_alert #(
   parameter int CODE_W        = 8,
   parameter int DATA_W        = 8,
   parameter int WARN_SET_BIT  = 6,
   parameter int WARN_CLR_BIT  = 5,
   parameter int HOT_SET_BIT   = 7,
   parameter int HOT_CLR_BIT   = 6,
   parameter int STAT_WARN_POS = 1,
   parameter logic [tza_pkg::ZONE_N*CODE_W-1:0] ZONE_THR =
      {8'd150, 8'd149, 8'd148, 8'd120, 8'd100, 8'd80, 8'd60, 8'd40}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              temp_vld,
   input  logic [CODE_W-1:0] temp_code,
   input  logic              rd_stb,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              alert_n,
   output logic              hot_n
);
   import tza_pkg::*;

   localparam int ZN = ZONE_N;

   if (DATA_W < ZN) begin : g_dw_chk
      $error("read bus narrower than zone register");
   end
   if (STAT_WARN_POS >= DATA_W) begin : g_pos_chk
      $error("status warning position outside read bus");
   end

   logic [ZN-1:0]     zone_nxt;
   logic [ZN-1:0]     zone_q;
   logic              warn_q;
   logic              warn_nxt;
   logic              hot_q;
   logic              hot_nxt;
   logic              hot_n_q;
   logic              stat_rd;
   logic [DATA_W-1:0] stat_vec;
   logic [DATA_W-1:0] zone_vec;
   logic [DATA_W-1:0] rd_q;

   tza_zone_enc #(.CODE_W(CODE_W), .ZONE_N(ZN), .THR(ZONE_THR)) u_zone (
      .clk(clk), .rst_n(rst_n), .upd(temp_vld), .code(temp_code),
      .zone_nxt(zone_nxt), .zone_q(zone_q)
   );

   tza_hyst_flag #(.ZONE_N(ZN), .SET_BIT(WARN_SET_BIT), .CLR_BIT(WARN_CLR_BIT)) u_warn (
      .upd(temp_vld), .flag_q(warn_q), .zone_old(zone_q), .zone_new(zone_nxt),
      .flag_nxt(warn_nxt)
   );

   tza_hyst_flag #(.ZONE_N(ZN), .SET_BIT(HOT_SET_BIT), .CLR_BIT(HOT_CLR_BIT)) u_hot (
      .upd(temp_vld), .flag_q(hot_q), .zone_old(zone_q), .zone_new(zone_nxt),
      .flag_nxt(hot_nxt)
   );

   assign stat_rd = rd_stb & (tza_sel_e'(rd_sel) == SEL_STATUS);

   tza_alert_ctl u_alert (
      .clk(clk), .rst_n(rst_n), .chg(warn_nxt ^ warn_q), .rd_clr(stat_rd),
      .alert_n(alert_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_q  <= 1'b0;
         hot_n_q <= 1'b1;
      end else begin
         warn_q  <= warn_nxt;
         hot_n_q <= ~hot_nxt;
      end
   end

   assign hot_q = ~hot_n_q;
   assign hot_n = hot_n_q;

   genvar b;
   for (b = 0; b < DATA_W; b++) begin : g_rdv
      if (b == STAT_WARN_POS) begin : g_flag
         assign stat_vec[b] = warn_q;
      end else begin : g_zero
         assign stat_vec[b] = 1'b0;
      end
      if (b < ZN) begin : g_zb
         assign zone_vec[b] = zone_q[b];
      end else begin : g_zp
         assign zone_vec[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_stb) begin
         rd_q <= (tza_sel_e'(rd_sel) == SEL_ZONE) ? zone_vec : stat_vec;
      end
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/tza_chk.sv
module tza_chk #(
   parameter int CODE_W = 8,
   parameter int ZONE_N = 8,
   parameter int HOT_BIT = 7,
   parameter logic [CODE_W-1:0] HOT_THR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              temp_vld,
   input logic [CODE_W-1:0] temp_code,
   input logic              rd_stb,
   input logic              rd_sel,
   input logic              alert_n,
   input logic              hot_n,
   input logic [ZONE_N-1:0] zone,
   input logic              warn
);
   AST_ZONE_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      ((zone & ZONE_N'(zone + 1'b1)) == '0)); // R1

   AST_ZONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_vld |=> $stable(zone)); // R2

   AST_HOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && !zone[HOT_BIT] && temp_code >= HOT_THR) |=> !hot_n); // R5

   AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hot_n && !temp_vld) |=> !hot_n); // R6

   AST_WARN_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
      (warn != $past(warn)) |-> !alert_n); // R7

   AST_READ_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rd_sel && !temp_vld) |=> alert_n); // R8
endmodule

bind thermal_zone_alert tza_chk #(
   .CODE_W(CODE_W), .ZONE_N(tza_pkg::ZONE_N), .HOT_BIT(HOT_SET_BIT),
   .HOT_THR(ZONE_THR[HOT_SET_BIT*CODE_W +: CODE_W])
) u_chk (
   .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_code(temp_code),
   .rd_stb(rd_stb), .rd_sel(rd_sel), .alert_n(alert_n), .hot_n(hot_n),
   .zone(zone_q), .warn(warn_q)
);

// File: tb/thermal_zone_alert_tb.sv
module thermal_zone_alert_tb;
   localparam int CODE_W = 8;
   localparam int DATA_W = 8;
   localparam int K_ALERT = 0;
   localparam int K_HOT   = 1;
   localparam int K_RD    = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              temp_vld = 1'b0;
   logic [CODE_W-1:0] temp_code = '0;
   logic              rd_stb = 1'b0;
   logic              rd_sel = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              alert_n;
   logic              hot_n;

   always #4 clk = ~clk;

   thermal_zone_alert u_dut (
      .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_code(temp_code),
      .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
      .alert_n(alert_n), .hot_n(hot_n)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // reference model state
   int   thr [8] = '{40, 60, 80, 100, 120, 148, 149, 150};
   logic [7:0] m_zone = '0;
   logic m_warn = 0, m_hot = 0, m_pend = 0;
   logic [7:0] m_rd = '0;

   // scoreboard queues
   int    q_due [$];
   int    q_kind [$];
   int    q_exp [$];
   string q_req [$];

   function automatic logic [7:0] zone_of(input int code);
      logic [7:0] z;
      for (int i = 0; i < 8; i++) z[i] = (code >= thr[i]);
      return z;
   endfunction

   task automatic push(input int kind, input int exp, input string req);
      q_due.push_back(cyc + 1);
      q_kind.push_back(kind);
      q_exp.push_back(exp);
      q_req.push_back(req);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: compare outputs against due items
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
         int k, e, a;
         string r;
         k = q_kind.pop_front();
         e = q_exp.pop_front();
         r = q_req.pop_front();
         void'(q_due.pop_front());
         a = (k == K_ALERT) ? int'(alert_n) : (k == K_HOT) ? int'(hot_n) : int'(rd_data);
         check(r, a, e);
      end
   end

   // driver: one cycle of stimulus plus expected results
   task automatic step(input logic vld, input int code, input logic rd, input logic sel,
                       input string req);
      logic [7:0] zn;
      logic wn, hn, chg;
      @(negedge clk);
      temp_vld = vld; temp_code = CODE_W'(code); rd_stb = rd; rd_sel = sel;
      zn = vld ? zone_of(code) : m_zone;
      wn = m_warn; hn = m_hot;
      if (vld) begin
         if (m_zone[5] && !zn[5]) wn = 0; else if (!m_zone[6] && zn[6]) wn = 1;
         if (m_zone[6] && !zn[6]) hn = 0; else if (!m_zone[7] && zn[7]) hn = 1;
      end
      chg = (wn != m_warn);
      if (rd) m_rd = sel ? m_zone : {6'b0, m_warn, 1'b0};
      if (chg) m_pend = 1; else if (rd && !sel) m_pend = 0;
      m_zone = zn; m_warn = wn; m_hot = hn;
      push(K_ALERT, int'(!m_pend), req);
      push(K_HOT, int'(!m_hot), req);
      push(K_RD, int'(m_rd), req);
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=complete");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 alert_n", int'(alert_n), 1);
      check("R10 hot_n", int'(hot_n), 1);
      check("R10 rd_data", int'(rd_data), 0);
      @(negedge clk); rst_n = 1'b1;
      step(0, 0, 1, 0, "R10 status");
      step(0, 0, 1, 1, "R10 zone");
      // R2: codes without strobe ignored
      step(0, 200, 0, 0, "R2 no strobe");
      step(0, 200, 0, 0, "R2 no strobe");
      step(0, 0, 1, 1, "R2 zone after no strobe");
      // R1: zone levels
      step(1, 50, 0, 0, "R1 code 50");
      step(0, 0, 1, 1, "R1 zone 50");
      step(1, 120, 1, 1, "R1 code 120");
      step(0, 0, 1, 1, "R1 zone 120");
      // R3 / R7: warning set
      step(1, 149, 0, 0, "R3 R7 warn set");
      step(0, 0, 0, 0, "R11 hold");
      step(0, 0, 1, 0, "R3 R8 status read");
      // R5: hot
      step(1, 150, 0, 0, "R5 hot set");
      step(1, 149, 0, 0, "R6 hot held at 149");
      step(1, 148, 0, 0, "R6 hot release, R4 warn held");
      step(0, 0, 1, 0, "R4 status still set");
      step(1, 147, 0, 0, "R4 R7 warn clear");
      step(0, 0, 1, 1, "R8 zone read keeps alert");
      step(0, 0, 1, 0, "R8 status read releases");
      // R9: jump hot, then read together with clear
      step(1, 200, 0, 0, "R3 R5 jump");
      step(0, 0, 1, 0, "R8 release");
      step(1, 10, 1, 0, "R9 read with change");
      step(0, 0, 0, 0, "R9 alert kept");
      step(0, 0, 1, 0, "R9 status after");
      step(0, 0, 1, 1, "R1 zone after cold");
      step(0, 0, 0, 0, "R11 idle");
      @(negedge clk); temp_vld = 0; rd_stb = 0;
      while (q_due.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      finish_run();
   end
endmodule